// File: doc/BRIEF.md
# Multiplexed External Data-Memory Bridge

This block sits between a processor's data-memory request port and an external asynchronous byte-wide SRAM. Data addresses at or above a configurable base (0x0260 by default) are routed off chip. Addresses below the base belong to on-chip storage and I/O and are left to other logic. Each external access time-shares one 8-bit pin group. That group first carries the low address byte while an address latch enable pulse tells an external latch to capture it. It then carries the data byte. The upper address byte has its own pin group.

Two control inputs shape the interface. The memory-mode enable gives the pin groups to the bridge. When the enable is low, the pins carry the ordinary general-purpose port values supplied from outside. The wait bit lengthens each access by one strobe cycle. The bridge raises a stall output for every cycle the access runs beyond a normal internal access, so the processor pipeline can freeze. A read returns its byte together with a one-cycle valid flag.

Top module: `xmem_bridge`

## Requirements
- R1: A request with an address below 0x0260 never pulses the latch enable or either strobe. A request at 0x0260 or above, with the enable set, begins an access in the next cycle.
- R2: With the enable clear, no access starts, the latch enable stays 0, and both strobes stay 1. Both pin groups then show the general-purpose output values and per-bit output enables.
- R3: The cycle after an accepted request is the latch phase. In that cycle the latch enable is 1, the low pin group drives the address bits [7:0], and its output enable is all ones.
- R4: The high pin group shows address bits [15:8] from the latch phase to the end of the access, and is driven on every bit while the enable is set.
- R5: A write drives the data byte on the low group from the first strobe cycle through the hold cycle. The write strobe (active low) is 0 only in the strobe cycles and returns to 1 in the hold cycle.
- R6: A read releases the low group (output enable 0) from the first strobe cycle onward. The read strobe is 0 only in the strobe cycles. The returned byte is the bus value in the last strobe cycle. It is presented with the valid flag set in the hold cycle. The two strobes are never 0 together.
- R7: An access lasts three cycles (latch, strobe, hold) when the wait bit is clear. It lasts four cycles (latch, strobe, strobe, hold) when the wait bit is set. The wait bit is sampled when the request is accepted. Stall is 1 for one cycle (the latch phase) without wait, and for two cycles (latch and first strobe) with wait.
- R8: A request presented in the hold cycle is accepted, and the next cycle is a new latch phase.
- R9: During and after reset the bridge is idle: latch enable 0, both strobes 1, stall 0.
- R10: A request presented during the latch or strobe cycles of an access is ignored. The address pins do not change and no extra access follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_en | input | 1 | Gives the pin groups to external memory |
| mem_wait | input | 1 | Adds one strobe cycle per access |
| req_valid | input | 1 | Data-memory request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Data address |
| req_wdata | input | 8 | Write byte |
| cpu_stall | output | 1 | Freeze the pipeline this cycle |
| rd_data | output | 8 | Byte returned by a read |
| rd_valid | output | 1 | rd_data valid (hold cycle of a read) |
| gp_lo_out | input | 8 | Port value for the low pin group when not in memory mode |
| gp_lo_oe | input | 8 | Port output enables, low group |
| gp_hi_out | input | 8 | Port value for the high pin group when not in memory mode |
| gp_hi_oe | input | 8 | Port output enables, high group |
| pin_lo_out | output | 8 | Low pin group output (address low / data) |
| pin_lo_oe | output | 8 | Low pin group per-bit output enable |
| pin_lo_in | input | 8 | Low pin group input |
| pin_hi_out | output | 8 | High pin group output (address high) |
| pin_hi_oe | output | 8 | High pin group per-bit output enable |
| pin_ale | output | 1 | Address latch enable |
| pin_rd_n | output | 1 | Read strobe, active low |
| pin_wr_n | output | 1 | Write strobe, active low |

## Verification
The bench aims at the address boundary 0x025F/0x0260. A comparator that is off by one would strobe the external memory for an internal address, or miss the first external byte. Back-to-back requests in the hold cycle and requests arriving in the middle of an access are also driven. A bridge with the wrong accept window would either drop the follow-on access or start a spurious one and move the high address mid-cycle. Wait-state runs check the stall count and the read capture point. A bridge that samples the bus one cycle early would return stale data, and one that miscounts stall would let the processor run ahead. Mode-switch runs confirm the pins return to the port values.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_LATCH = 3'd1,
    PH_STRB = 3'd2,
    PH_WAIT = 3'd3,
    PH_HOLD = 3'd4
  } phase_e;
endpackage

// File: rtl/xmem_rst_sync.sv
module xmem_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/xmem_decode.sv
module xmem_decode #(
  parameter int          AW       = 16,
  parameter logic [15:0] EXT_BASE = 16'h0260
) (
  input  logic [AW-1:0] addr,
  output logic          is_ext
);
  localparam logic [AW-1:0] BASE = AW'(EXT_BASE);
  assign is_ext = (addr >= BASE);
endmodule

// File: rtl/xmem_pinmux.sv
module xmem_pinmux #(
  parameter int W = 8
) (
  input  logic         mem_mode,
  input  logic [W-1:0] mem_out,
  input  logic         mem_drive,
  input  logic [W-1:0] gp_out,
  input  logic [W-1:0] gp_oe,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    always_comb begin
      if (mem_mode) begin
        pin_out[b] = mem_out[b];
        pin_oe[b]  = mem_drive;
      end else begin
        pin_out[b] = gp_out[b];
        pin_oe[b]  = gp_oe[b];
      end
    end
  end
endmodule

// File: rtl/xmem_seq.sv
module xmem_seq
  import xmem_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_sn,
  input  logic          start,
  input  logic          start_we,
  input  logic          start_wait,
  input  logic [AW-1:0] start_addr,
  input  logic [DW-1:0] start_wdata,
  input  logic [DW-1:0] bus_in,
  output logic          can_accept,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic          lo_drive,
  output logic [DW-1:0] lo_val,
  output logic [AW-DW-1:0] hi_val,
  output logic          stall,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  localparam int HW = AW - DW;

  phase_e        phase_q, phase_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] wdata_q, wdata_d;
  logic [DW-1:0] rdata_q, rdata_d;
  logic          we_q, we_d;
  logic          wait_q, wait_d;
  logic          last_strobe;
  logic          strobing;

  assign can_accept  = (phase_q == PH_IDLE) || (phase_q == PH_HOLD);
  assign strobing    = (phase_q == PH_STRB) || (phase_q == PH_WAIT);
  assign last_strobe = ((phase_q == PH_STRB) && !wait_q) || (phase_q == PH_WAIT);

  always_comb begin
    phase_d = phase_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    rdata_d = rdata_q;
    we_d    = we_q;
    wait_d  = wait_q;
    unique case (phase_q)
      PH_IDLE:  phase_d = start ? PH_LATCH : PH_IDLE;
      PH_LATCH: phase_d = PH_STRB;
      PH_STRB:  phase_d = wait_q ? PH_WAIT : PH_HOLD;
      PH_WAIT:  phase_d = PH_HOLD;
      PH_HOLD:  phase_d = start ? PH_LATCH : PH_IDLE;
      default:  phase_d = PH_IDLE;
    endcase
    if (start && can_accept) begin
      addr_d  = start_addr;
      wdata_d = start_wdata;
      we_d    = start_we;
      wait_d  = start_wait;
    end
    if (last_strobe && !we_q) rdata_d = bus_in;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      phase_q <= PH_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      we_q    <= 1'b0;
      wait_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      rdata_q <= rdata_d;
      we_q    <= we_d;
      wait_q  <= wait_d;
    end
  end

  assign ale      = (phase_q == PH_LATCH);
  assign wr_n     = !(strobing && we_q);
  assign rd_n     = !(strobing && !we_q);
  assign lo_drive = ale || (we_q && (strobing || (phase_q == PH_HOLD)));
  assign lo_val   = ale ? addr_q[DW-1:0] : wdata_q;
  assign hi_val   = addr_q[AW-1 -: HW];
  assign stall    = ale || ((phase_q == PH_STRB) && wait_q);
  assign rdata    = rdata_q;
  assign rvalid   = (phase_q == PH_HOLD) && !we_q;

  assert_ale_single_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    ale |=> !ale);
  assert_ale_stalls_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    ale |-> stall);
  assert_hi_stable_R4: assert property (@(posedge clk) disable iff (!rst_sn)
    (strobing || phase_q == PH_HOLD) |-> $stable(hi_val));
  assert_wr_drives_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    !wr_n |-> lo_drive);
  assert_rd_released_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    !rd_n |-> !lo_drive);
  assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    !(!rd_n && !wr_n));
  assert_strobe_follows_latch_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    ale |=> (!rd_n || !wr_n));
endmodule

// File: rtl/xmem_bridge.sv
module xmem_bridge #(
  parameter int          AW       = 16,
  parameter int          DW       = 8,
  parameter logic [15:0] EXT_BASE = 16'h0260
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mem_en,
  input  logic          mem_wait,
  input  logic          req_valid,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          cpu_stall,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  input  logic [DW-1:0] gp_lo_out,
  input  logic [DW-1:0] gp_lo_oe,
  input  logic [AW-DW-1:0] gp_hi_out,
  input  logic [AW-DW-1:0] gp_hi_oe,
  output logic [DW-1:0] pin_lo_out,
  output logic [DW-1:0] pin_lo_oe,
  input  logic [DW-1:0] pin_lo_in,
  output logic [AW-DW-1:0] pin_hi_out,
  output logic [AW-DW-1:0] pin_hi_oe,
  output logic          pin_ale,
  output logic          pin_rd_n,
  output logic          pin_wr_n
);
  localparam int HW = AW - DW;

  logic          rst_sn;
  logic          is_ext;
  logic          can_accept;
  logic          start;
  logic          s_ale, s_rd_n, s_wr_n, s_drive, s_stall;
  logic [DW-1:0] s_lo;
  logic [HW-1:0] s_hi;

  xmem_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn)
  );

  xmem_decode #(.AW(AW), .EXT_BASE(EXT_BASE)) u_dec (
    .addr(req_addr), .is_ext(is_ext)
  );

  assign start = req_valid && mem_en && is_ext && can_accept;

  xmem_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst_sn(rst_sn),
    .start(start), .start_we(req_we), .start_wait(mem_wait),
    .start_addr(req_addr), .start_wdata(req_wdata), .bus_in(pin_lo_in),
    .can_accept(can_accept), .ale(s_ale), .rd_n(s_rd_n), .wr_n(s_wr_n),
    .lo_drive(s_drive), .lo_val(s_lo), .hi_val(s_hi), .stall(s_stall),
    .rdata(rd_data), .rvalid(rd_valid)
  );

  xmem_pinmux #(.W(DW)) u_mux_lo (
    .mem_mode(mem_en), .mem_out(s_lo), .mem_drive(s_drive),
    .gp_out(gp_lo_out), .gp_oe(gp_lo_oe),
    .pin_out(pin_lo_out), .pin_oe(pin_lo_oe)
  );

  xmem_pinmux #(.W(HW)) u_mux_hi (
    .mem_mode(mem_en), .mem_out(s_hi), .mem_drive(1'b1),
    .gp_out(gp_hi_out), .gp_oe(gp_hi_oe),
    .pin_out(pin_hi_out), .pin_oe(pin_hi_oe)
  );

  assign pin_ale   = mem_en && s_ale;
  assign pin_rd_n  = !mem_en || s_rd_n;
  assign pin_wr_n  = !mem_en || s_wr_n;
  assign cpu_stall = s_stall;

  assert_off_quiet_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    !mem_en |-> (!pin_ale && pin_rd_n && pin_wr_n));
  assert_internal_no_start_R1: assert property (@(posedge clk) disable iff (!rst_sn)
    (req_valid && !is_ext && can_accept) |=> !pin_ale);
endmodule

// File: tb/xmem_bridge_bench.sv
module xmem_bridge_bench;
  logic        clk = 1'b0;
  logic        rst_n, mem_en, mem_wait, req_valid, req_we;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata, gp_lo_out, gp_lo_oe, gp_hi_out, gp_hi_oe, pin_lo_in;
  logic        cpu_stall, rd_valid, pin_ale, pin_rd_n, pin_wr_n;
  logic [7:0]  rd_data, pin_lo_out, pin_lo_oe, pin_hi_out, pin_hi_oe;

  int nchk = 0, nfail = 0, cyc = 0;

  always #10 clk = ~clk;

  xmem_bridge u_xmem_bridge (
    .clk(clk), .rst_n(rst_n), .mem_en(mem_en), .mem_wait(mem_wait),
    .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .cpu_stall(cpu_stall), .rd_data(rd_data),
    .rd_valid(rd_valid), .gp_lo_out(gp_lo_out), .gp_lo_oe(gp_lo_oe),
    .gp_hi_out(gp_hi_out), .gp_hi_oe(gp_hi_oe), .pin_lo_out(pin_lo_out),
    .pin_lo_oe(pin_lo_oe), .pin_lo_in(pin_lo_in), .pin_hi_out(pin_hi_out),
    .pin_hi_oe(pin_hi_oe), .pin_ale(pin_ale), .pin_rd_n(pin_rd_n),
    .pin_wr_n(pin_wr_n)
  );

  // external SRAM contents and latch
  logic [7:0] sram [int];
  logic [7:0] lat_lo = 8'h00;

  function automatic logic [7:0] sram_rd(input logic [15:0] a);
    if (sram.exists(int'(a))) return sram[int'(a)];
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // reference model: position k in the current access (-1 idle), length len
  int         k = -1, len = 3;
  logic       m_we = 1'b0;
  logic [15:0] m_addr = 16'h0000;
  logic [7:0] m_wdata = 8'h00, m_rdata = 8'h00;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      k = -1; m_addr = 16'h0000;
    end else begin
      if (k >= 0 && !m_we && k == len - 2) m_rdata = sram_rd(m_addr);
      if ((k < 0 || k == len - 1) && req_valid && mem_en && req_addr >= 16'h0260) begin
        k = 0; len = mem_wait ? 4 : 3;
        m_we = req_we; m_addr = req_addr; m_wdata = req_wdata;
      end else if (k >= 0) begin
        k = (k == len - 1) ? -1 : k + 1;
      end
    end
  end

  // per-cycle comparison and SRAM behaviour, away from the active edge
  always @(negedge clk) begin
    logic strb;
    logic [7:0] e_oe;
    if (rst_n) begin
      strb = (k >= 1) && (k <= len - 2);
      if (mem_en) begin
        chk("R3 ale", pin_ale, k == 0);
        chk("R5 wr_n", pin_wr_n, !(strb && m_we));
        chk("R6 rd_n", pin_rd_n, !(strb && !m_we));
        chk("R7 stall", cpu_stall, (k == 0) || (len == 4 && k == 1));
        chk("R4 hi out", pin_hi_out, m_addr[15:8]);
        chk("R4 hi oe", pin_hi_oe, 8'hFF);
        e_oe = ((k == 0) || (k >= 1 && m_we)) ? 8'hFF : 8'h00;
        chk("R6 lo oe", pin_lo_oe, e_oe);
        if (k == 0) chk("R3 lo addr", pin_lo_out, m_addr[7:0]);
        else if (k >= 1 && m_we) chk("R5 lo data", pin_lo_out, m_wdata);
        chk("R6 rvalid", rd_valid, (k == len - 1) && !m_we);
        if (k == len - 1 && !m_we) chk("R6 rdata", rd_data, m_rdata);
      end else begin
        chk("R2 ale", pin_ale, 1'b0);
        chk("R2 strobes", {pin_rd_n, pin_wr_n}, 2'b11);
        chk("R2 lo", {pin_lo_out, pin_lo_oe}, {gp_lo_out, gp_lo_oe});
        chk("R2 hi", {pin_hi_out, pin_hi_oe}, {gp_hi_out, gp_hi_oe});
      end
    end
    if (pin_ale) lat_lo = pin_lo_out;
    if (!pin_wr_n) sram[int'({pin_hi_out, lat_lo})] = pin_lo_out;
    pin_lo_in = !pin_rd_n ? sram_rd({pin_hi_out, lat_lo}) : 8'h00;
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 100000) begin
    nfail++;
    $display("FAIL watchdog expired, actual=hung expected=done");
    finish_run();
  end

  task automatic go(input logic we, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); #2;
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    @(negedge clk); #2;
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; mem_en = 1'b0; mem_wait = 1'b0; req_valid = 1'b0; req_we = 1'b0;
    req_addr = 16'h0; req_wdata = 8'h0; pin_lo_in = 8'h0;
    gp_lo_out = 8'h3C; gp_lo_oe = 8'h0F; gp_hi_out = 8'hC3; gp_hi_oe = 8'hF0;
    idle(3); #2;
    chk("R9 reset ale", pin_ale, 1'b0);
    chk("R9 reset strobes", {pin_rd_n, pin_wr_n}, 2'b11);
    chk("R9 reset stall", cpu_stall, 1'b0);
    rst_n = 1'b1;
    idle(4);

    // R2: disabled, external request ignored
    go(1'b1, 16'h1234, 8'h77);
    chk("R2 no access", {pin_ale, pin_wr_n}, 2'b01);
    idle(3);

    mem_en = 1'b1;
    idle(2);
    // R1 boundary
    go(1'b0, 16'h025F, 8'h00);
    chk("R1 internal no ale", pin_ale, 1'b0);
    idle(1); #2;
    chk("R1 internal no strobe", {pin_rd_n, pin_wr_n}, 2'b11);
    idle(2);
    go(1'b0, 16'h0260, 8'h00);
    chk("R1 first external starts", pin_ale, 1'b1);
    idle(4);

    // R5/R6 no wait
    go(1'b1, 16'h0300, 8'hA5); idle(4);
    go(1'b0, 16'h0300, 8'h00); idle(1); idle(1); #2;
    chk("R6 readback", {rd_valid, rd_data}, {1'b1, 8'hA5});
    idle(3);
    go(1'b0, 16'h8001, 8'h00); idle(4);

    // R7 wait state
    mem_wait = 1'b1;
    go(1'b1, 16'hFFFF, 8'h3E);
    chk("R7 stall latch", cpu_stall, 1'b1);
    idle(1); #2; chk("R7 stall strobe1", cpu_stall, 1'b1);
    idle(1); #2; chk("R7 no stall strobe2", cpu_stall, 1'b0);
    mem_wait = 1'b0;  // sampled at accept only
    idle(1); #2; chk("R7 hold wr_n", pin_wr_n, 1'b1);
    idle(3);
    mem_wait = 1'b1;
    go(1'b0, 16'hFFFF, 8'h00); idle(2); idle(1); #2;
    chk("R6 wait readback", {rd_valid, rd_data}, {1'b1, 8'h3E});
    mem_wait = 1'b0;
    idle(3);

    // R8 back-to-back
    go(1'b1, 16'h4000, 8'h11);
    idle(1); idle(1); #2;
    req_valid = 1'b1; req_we = 1'b0; req_addr = 16'h4000;
    idle(1); #2;
    chk("R8 fresh latch", pin_ale, 1'b1);
    chk("R8 lo addr", pin_lo_out, 8'h00);
    req_valid = 1'b0;
    idle(5);

    // R10 request mid-access ignored
    @(negedge clk); #2;
    req_valid = 1'b1; req_we = 1'b0; req_addr = 16'h5500;
    idle(1); #2;
    req_addr = 16'h7700;
    idle(1); #2;
    req_valid = 1'b0;
    chk("R10 hi unchanged", pin_hi_out, 8'h55);
    idle(1); idle(1); #2;
    chk("R10 no extra access", pin_ale, 1'b0);
    idle(3);

    // R2 switch back to port use
    mem_en = 1'b0; gp_lo_out = 8'h81; gp_hi_oe = 8'h18;
    idle(1); #2;
    chk("R2 port restore", {pin_lo_out, pin_hi_oe}, {8'h81, 8'h18});
    idle(3);
    finish_run();
  end
endmodule